// File: doc/BRIEF.md
# Paged Digital I/O Controller

This block is a 48-channel digital I/O controller reached through a 16-byte window on a simple synchronous register bus. Six byte-wide ports drive their pins open-drain: a written 1 releases the pin and a written 0 pulls it low. A read of a port returns the pin level after a two-flop synchronizer. The first three ports (channels 0 to 23) also have edge detection. Each of their channels has a polarity select and an interrupt enable. When an enabled edge occurs, a sticky identification flag is set. One interrupt output is the OR of all these flags.

A write-only control byte has two jobs. Its top two bits pick which bank is visible at offsets 8 to 10: polarity, enable or interrupt-ID. Its low six bits lock individual ports against writes. A read-only summary byte shows which interrupt-ID registers hold any flag, so software can find the source without changing the page.

Top module: `pdio_top`

## Requirements
- R1: After reset every pin is released (`pinDriveLow` all 0), `irq` is 0, the page is 0, every lock is clear, and every polarity, enable and interrupt-ID bit is 0.
- R2: Offsets 0 to 5 are ports 0 to 5. Port n owns channels 8n+7..8n. A write to an unlocked port sets `pinDriveLow` to the inverse of the written byte. A read returns the pin levels seen through two synchronizer flops.
- R3: A write to offset 7 sets the control byte. Bit n (n = 0..5) set to 1 locks port n, and a write to a locked port leaves its output latch unchanged.
- R4: Bits 7:6 of offset 7 select the page. At offsets 8, 9 and 10, which serve ports 0, 1 and 2, page 1 gives polarity, page 2 gives interrupt enable and page 3 gives interrupt-ID.
- R5: Reads of offset 7, of offsets 8 to 10 on pages 0, 1 and 2, and of offsets 11 to 15 return 0x00. Writes to offsets 8 to 10 on page 0 have no effect.
- R6: An enabled channel sets its interrupt-ID bit on a rising synchronized edge when its polarity bit is 0, and on a falling edge when it is 1.
- R7: Edges on channels that are not enabled, edges opposite to the selected polarity, and any activity on ports 3 to 5 never set a flag.
- R8: Writing 0 to an interrupt-ID bit on page 3 clears it. Writing 1 leaves it unchanged. An edge in the same cycle as a clear wins, so the bit stays set.
- R9: Offset 6 reads with bit n = 1 exactly when interrupt-ID register n has any bit set. Bits 7:3 read 0.
- R10: `irq` is 1 exactly when at least one interrupt-ID bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWe | input | 1 | Write strobe for this cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| pinIn | input | 48 | Sampled pin levels |
| pinDriveLow | output | 48 | 1 pulls the matching pin low |
| irq | output | 1 | Interrupt request |

## Verification
A vector table first exercises the register map. It writes distinct byte patterns (A5, 3C, 00) to the ports, so that inversion and port mapping can be told apart. It writes to locked and unlocked ports, so that a blocked write can be told from one that took effect. It reads every paged offset on each page, so that the write-only banks can be told from the readable ID bank.

Directed tests then move single pin levels. On channel 0 with rising polarity and on channel 15 with falling polarity, each edge is applied in both directions, so a matching edge can be told from an opposite one. A toggle on port 5 shows that ports without edge logic stay silent. Clears with all-ones and with single-zero masks show which bits a write to the ID register actually drops.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  localparam int PORT_W     = 8;
  localparam int NUM_PORTS  = 6;
  localparam int EDGE_PORTS = 3;
  localparam int ADDR_W     = 4;
  localparam int CH_W       = PORT_W * NUM_PORTS;
  localparam int IDX_W      = $clog2(NUM_PORTS);
  localparam int PEND_OFF   = NUM_PORTS;
  localparam int CTRL_OFF   = NUM_PORTS + 1;
  localparam int PAGED_OFF  = 8;
  localparam int LOCK_W     = NUM_PORTS;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;

  typedef enum logic [1:0] {
    RS_PORT,
    RS_PEND,
    RS_ID,
    RS_ZERO
  } rdsel_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0]  portWr;
    logic [EDGE_PORTS-1:0] polWr;
    logic [EDGE_PORTS-1:0] enWr;
    logic [EDGE_PORTS-1:0] idWr;
    logic [PORT_W-1:0]     wrData;
    rdsel_e                rdSel;
    logic [IDX_W-1:0]      rdIdx;
  } strobe_t;
endpackage

// File: rtl/pdio_ctrl.sv
module pdio_ctrl
  import pdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [PORT_W-1:0] busWrData,
  output strobe_t           st
);
  page_e             pageR;
  logic [LOCK_W-1:0] lockR;
  logic              ctrlHit;

  assign ctrlHit = busWe && (busAddr == ADDR_W'(CTRL_OFF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageR <= PG_NONE;
      lockR <= '0;
    end else if (ctrlHit) begin
      pageR <= page_e'(busWrData[PORT_W-1 -: 2]);
      lockR <= busWrData[LOCK_W-1:0];
    end
  end

  always_comb begin
    st        = '0;
    st.rdSel  = RS_ZERO;
    st.wrData = busWrData;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (busAddr == ADDR_W'(i)) begin
        st.rdSel     = RS_PORT;
        st.rdIdx     = IDX_W'(i);
        st.portWr[i] = busWe && !lockR[i];
      end
    end
    if (busAddr == ADDR_W'(PEND_OFF)) st.rdSel = RS_PEND;
    for (int k = 0; k < EDGE_PORTS; k++) begin
      if (busAddr == ADDR_W'(PAGED_OFF + k)) begin
        case (pageR)
          PG_POL: st.polWr[k] = busWe;
          PG_EN:  st.enWr[k]  = busWe;
          PG_ID: begin
            st.idWr[k] = busWe;
            st.rdSel   = RS_ID;
            st.rdIdx   = IDX_W'(k);
          end
          default: ;
        endcase
      end
    end
  end

  // R4: at most one register strobe per bus cycle
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.portWr, st.polWr, st.enWr, st.idWr}));

  // R4: control byte write loads the page field
  p_page_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |=> pageR == page_e'($past(busWrData[PORT_W-1 -: 2])));

  // R3: a locked port never receives a write strobe
  p_lock_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && lockR[0] && busAddr == '0) |-> !st.portWr[0]);
endmodule

// File: rtl/pdio_datapath.sv
module pdio_datapath
  import pdio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [CH_W-1:0]   pinIn,
  output logic [CH_W-1:0]   pinDriveLow,
  output logic [PORT_W-1:0] rdData,
  output logic              irq
);
  localparam int EDGE_CH = EDGE_PORTS * PORT_W;

  logic [PORT_W-1:0] portLat [NUM_PORTS];
  logic [CH_W-1:0]   syncR   [SYNC_STAGES];
  logic [CH_W-1:0]   pinNow;
  logic [EDGE_CH-1:0] prevR;
  logic [PORT_W-1:0] polR [EDGE_PORTS];
  logic [PORT_W-1:0] enR  [EDGE_PORTS];
  logic [PORT_W-1:0] idR  [EDGE_PORTS];
  logic [EDGE_PORTS-1:0] pendVec;
  logic [EDGE_CH-1:0] idFlat;

  // output latches, open-drain drive
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              portLat[p] <= '1;
      else if (st.portWr[p])  portLat[p] <= st.wrData;
    end
    assign pinDriveLow[p*PORT_W +: PORT_W] = ~portLat[p];

    // R3/R2: latch moves only on its own strobe
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !st.portWr[p] |=> $stable(portLat[p]));
  end

  // input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      syncR[s] <= '0;
      else if (s == 0) syncR[s] <= pinIn;
      else            syncR[s] <= syncR[(s == 0) ? 0 : s-1];
    end
  end
  assign pinNow = syncR[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevR <= '0;
    else       prevR <= pinNow[EDGE_CH-1:0];
  end

  // edge banks
  for (genvar e = 0; e < EDGE_PORTS; e++) begin : g_edge
    logic [PORT_W-1:0] cur, old, rise, fall, hit, keep;
    assign cur  = pinNow[e*PORT_W +: PORT_W];
    assign old  = prevR[e*PORT_W +: PORT_W];
    assign rise = cur & ~old;
    assign fall = ~cur & old;
    assign hit  = enR[e] & ((polR[e] & fall) | (~polR[e] & rise));
    assign keep = st.idWr[e] ? st.wrData : '1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        polR[e] <= '0;
        enR[e]  <= '0;
        idR[e]  <= '0;
      end else begin
        if (st.polWr[e]) polR[e] <= st.wrData;
        if (st.enWr[e])  enR[e]  <= st.wrData;
        idR[e] <= (idR[e] & keep) | hit;
      end
    end
    assign pendVec[e] = |idR[e];
    assign idFlat[e*PORT_W +: PORT_W] = idR[e];

    // R7: a flag may only rise on an enabled channel
    p_flag_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
      ((idR[e] & ~$past(idR[e])) & ~$past(enR[e])) == '0);

    // R8: a flag may only drop when a page-3 write held a 0 there
    p_clear_by_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
      ((~idR[e] & $past(idR[e])) &
       ($past(st.idWr[e]) ? $past(st.wrData) : '1)) == '0);
  end

  assign irq = |idFlat;

  // R10: interrupt line agrees with the pending summary
  p_irq_vs_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq == (pendVec != '0));

  always_comb begin
    rdData = '0;
    case (st.rdSel)
      RS_PORT: begin
        for (int i = 0; i < NUM_PORTS; i++)
          if (st.rdIdx == IDX_W'(i)) rdData = pinNow[i*PORT_W +: PORT_W];
      end
      RS_PEND: rdData = PORT_W'(pendVec);
      RS_ID: begin
        for (int i = 0; i < EDGE_PORTS; i++)
          if (st.rdIdx == IDX_W'(i)) rdData = idR[i];
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pdio_top.sv
module pdio_top
  import pdio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [PORT_W-1:0] busWrData,
  output logic [PORT_W-1:0] busRdData,
  input  logic [CH_W-1:0]   pinIn,
  output logic [CH_W-1:0]   pinDriveLow,
  output logic              irq
);
  strobe_t st;

  pdio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .st(st)
  );

  pdio_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .pinIn(pinIn),
    .pinDriveLow(pinDriveLow), .rdData(busRdData), .irq(irq)
  );

  // R9: upper bits of the summary byte stay zero
  p_pending_upper_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(PEND_OFF)) |-> busRdData[PORT_W-1:EDGE_PORTS] == '0);

  // R5: offsets above the paged bank read as zero
  p_high_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(PAGED_OFF + EDGE_PORTS)) |-> busRdData == '0);
endmodule

// File: tb/sim_pdio_top.sv
module sim_pdio_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [47:0] extPins = '1;
  logic [47:0] pinIn;
  logic [47:0] pinDriveLow;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign pinIn = extPins & ~pinDriveLow;

  pdio_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinDriveLow(pinDriveLow), .irq(irq)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 8'hA5, 8'h00, 4'd2},  // R2 write port 0
    '{1'b0, 4'h0, 8'h00, 8'hA5, 4'd2},  // R2 read back pin level
    '{1'b1, 4'h3, 8'h3C, 8'h00, 4'd2},
    '{1'b0, 4'h3, 8'h00, 8'h3C, 4'd2},
    '{1'b1, 4'h7, 8'h01, 8'h00, 4'd3},  // R3 lock port 0
    '{1'b1, 4'h0, 8'h00, 8'h00, 4'd3},
    '{1'b0, 4'h0, 8'h00, 8'hA5, 4'd3},
    '{1'b1, 4'h7, 8'h00, 8'h00, 4'd3},  // R3 unlock
    '{1'b1, 4'h0, 8'h00, 8'h00, 4'd3},
    '{1'b0, 4'h0, 8'h00, 8'h00, 4'd3},
    '{1'b0, 4'h7, 8'h00, 8'h00, 4'd5},  // R5 control byte reads 0
    '{1'b0, 4'h8, 8'h00, 8'h00, 4'd5},  // R5 page 0 paged slot
    '{1'b0, 4'hF, 8'h00, 8'h00, 4'd5},
    '{1'b1, 4'h7, 8'h40, 8'h00, 4'd4},  // R4 page 1
    '{1'b1, 4'h8, 8'hFF, 8'h00, 4'd4},
    '{1'b0, 4'h8, 8'h00, 8'h00, 4'd5},
    '{1'b1, 4'h7, 8'h80, 8'h00, 4'd4},  // R4 page 2
    '{1'b1, 4'h9, 8'h12, 8'h00, 4'd4},
    '{1'b0, 4'h9, 8'h00, 8'h00, 4'd5},
    '{1'b1, 4'h7, 8'hC0, 8'h00, 4'd4},  // R4 page 3
    '{1'b0, 4'h8, 8'h00, 8'h00, 4'd4},
    '{1'b0, 4'h6, 8'h00, 8'h00, 4'd9},  // R9 nothing pending
    '{1'b1, 4'h0, 8'hFF, 8'h00, 4'd2},
    '{1'b1, 4'h3, 8'hFF, 8'h00, 4'd2},
    '{1'b1, 4'h7, 8'h00, 8'h00, 4'd4}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
    settle(3);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1;
    check(req, {40'h0, busRdData}, {40'h0, exp});
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(4);
    // R1 reset state
    check("R1", pinDriveLow, 48'h0);
    check("R1", {47'h0, irq}, 48'h0);
    rd(4'h0, 8'hFF, "R1");
    rd(4'h6, 8'h00, "R1");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].we) wr(VECS[v].addr, VECS[v].data);
      else begin
        string tag;
        tag = $sformatf("R%0d", VECS[v].req);
        rd(VECS[v].addr, VECS[v].exp, tag);
      end
    end

    // R6 rising edge on channel 0, polarity 0
    wr(4'h7, 8'h40); wr(4'h8, 8'h00);
    wr(4'h7, 8'h80); wr(4'h8, 8'h01);
    wr(4'h7, 8'hC0);
    @(negedge clk); extPins[0] = 1'b0; settle(5);
    rd(4'h8, 8'h00, "R7");                 // falling edge ignored
    check("R10", {47'h0, irq}, 48'h0);
    @(negedge clk); extPins[0] = 1'b1; settle(5);
    rd(4'h8, 8'h01, "R6");
    check("R10", {47'h0, irq}, 48'h1);
    rd(4'h6, 8'h01, "R9");

    // R8 clear semantics
    wr(4'h8, 8'hFF); rd(4'h8, 8'h01, "R8");
    wr(4'h8, 8'hFE); rd(4'h8, 8'h00, "R8");
    check("R10", {47'h0, irq}, 48'h0);

    // R6 falling edge on channel 15, polarity 1
    wr(4'h7, 8'h40); wr(4'h9, 8'h80);
    wr(4'h7, 8'h80); wr(4'h9, 8'h80);
    wr(4'h7, 8'hC0);
    @(negedge clk); extPins[15] = 1'b0; settle(5);
    rd(4'h9, 8'h80, "R6");
    rd(4'h6, 8'h02, "R9");
    wr(4'h9, 8'h7F); rd(4'h9, 8'h00, "R8");
    @(negedge clk); extPins[15] = 1'b1; settle(5);
    rd(4'h9, 8'h00, "R7");                 // opposite edge ignored

    // R7 ports without edge logic
    @(negedge clk); extPins[40] = 1'b0; settle(5);
    check("R7", {47'h0, irq}, 48'h0);
    rd(4'h5, 8'hFE, "R2");

    // R2 open-drain drive on port 4
    wr(4'h4, 8'h0F);
    check("R2", {40'h0, pinDriveLow[39:32]}, {40'h0, 8'hF0});
    rd(4'h4, 8'h0F, "R2");

    // R3 lock on port 5
    wr(4'h7, 8'hE0); wr(4'h5, 8'h00);
    check("R3", {40'h0, pinDriveLow[47:40]}, 48'h0);

    // R5 page 0 hides the ID bank and ignores writes
    wr(4'h7, 8'h00); wr(4'h9, 8'h00);
    rd(4'h9, 8'h00, "R5");

    // R1 reset in mid-run
    @(negedge clk); rstN = 1'b0; settle(2);
    check("R1", pinDriveLow, 48'h0);
    check("R1", {47'h0, irq}, 48'h0);
    rstN = 1'b1; settle(2);
    finishRun();
  end
endmodule